// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block arbitrates the interrupt sources of a small processor core. Each of its sources has a private enable bit. A build-time mask gives each source one of two kinds. A latched source records a one-cycle event in a sticky flag. A level source requests only while its input is held high. A single global enable bit gates every request. The block selects the lowest-numbered pending, enabled source. It presents that source's index on a vector output, and it raises a request line while the global enable is set.

The core acknowledges a request in the same cycle that it sees it. The acknowledge has three effects: the global enable drops in hardware, the latched flag of the chosen source clears, and the chosen index is registered as the taken vector. A return strobe sets the global enable again. After a return, the request line stays held low until the core reports one retired instruction, so the interrupted program always makes progress between two handlers. A handler may set the global enable itself to allow nesting. A disable command masks the request in the very cycle it is given.

Top module: `prio_irq_ctrl`

## Requirements
- R1: When several enabled sources are pending, `irq_vec` shows the lowest source index among them.
- R2: A high cycle on `src_in[i]` of a latched source (bit i of LEVEL_MASK is 0) sets `flags[i]` on the next edge, whatever the source and global enables are. The flag then stays set until it is cleared.
- R3: A latched flag clears on the edge of an accepted acknowledge that selects its index. It also clears on the edge after `flag_clr[i]` is 1. If an event arrives in the same cycle as either clear, the flag stays set.
- R4: A level source (bit i of LEVEL_MASK is 1) shows `flags[i]` equal to `src_in[i]` in the same cycle and requests only while that input is high. An input that falls before the source is enabled leaves no request behind.
- R5: An accepted acknowledge (`ack` high while `irq_req` is high) clears `gie` on the next edge and loads `taken_vec` with the `irq_vec` of that cycle.
- R6: `gie_set` or `reti` sets `gie` on the next edge. `gie_clr` or an accepted acknowledge clears it, and a clear wins over a set given in the same cycle.
- R7: From the edge that registers `reti` until the edge that registers a `retired` strobe, `irq_req` is low. It may rise in the cycle after the `retired` edge.
- R8: In any cycle where `gie_clr` is high, `irq_req` is low.
- R9: When `gie_set` is given inside a handler, any enabled pending source, including a higher-numbered one, can be taken again.
- R10: `irq_req` is high exactly when at least one source is pending and enabled, `gie` is 1, no return hold is active, and `gie_clr` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| src_in | input | NUM_SRC | Event strobes (latched sources) or condition levels (level sources) |
| src_en | input | NUM_SRC | Per-source enable |
| flag_clr | input | NUM_SRC | Write-one-to-clear for latched flags |
| gie_set | input | 1 | Set global enable |
| gie_clr | input | 1 | Clear global enable, effective in the same cycle |
| ack | input | 1 | Core accepts the presented request |
| reti | input | 1 | Return-from-interrupt strobe |
| retired | input | 1 | Main-program instruction retired strobe |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | VEC_W | Index of the winning source |
| taken_vec | output | VEC_W | Index registered on the last accepted acknowledge |
| gie | output | 1 | Global enable state |
| flags | output | NUM_SRC | Pending view: latched flags, raw level inputs |

## Verification
The hardest case to reach from the ports is a collision on one edge. In it, a return, a retire strobe, a fresh event on the flag being acknowledged, and a software clear of that same flag all land together while other sources wait. Directed sequences first build a return with lower-priority work pending. They then hold the retire strobe back and release it cycle by cycle. A long random phase follows, with dense acknowledge, return and event traffic, so that these edges meet often. Every cycle is compared against a behavioural model of the request, the vector, the flags and the global enable.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic {
        SRC_LATCHED = 1'b0,
        SRC_LEVEL   = 1'b1
    } src_kind_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter logic [NUM_SRC-1:0] LEVEL_MASK = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [NUM_SRC-1:0] sw_clr,
    input  logic [NUM_SRC-1:0] hw_clr,
    output logic [NUM_SRC-1:0] pend_raw
);
    typedef struct packed {
        logic [NUM_SRC-1:0] flag;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (src_kind_e'(LEVEL_MASK[i]) == SRC_LEVEL) begin
                bank_d.flag[i] = 1'b0;
            end else if (src_in[i]) begin
                bank_d.flag[i] = 1'b1;
            end else if (sw_clr[i] || hw_clr[i]) begin
                bank_d.flag[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        if (LEVEL_MASK[g]) begin : g_level
            assign pend_raw[g] = src_in[g];
        end else begin : g_latched
            assign pend_raw[g] = bank_q.flag[g];
        end
    end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int NUM_SRC = 8,
    localparam int VEC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] req,
    output logic               any,
    output logic [VEC_W-1:0]   idx,
    output logic [NUM_SRC-1:0] onehot
);
    always_comb begin
        any    = 1'b0;
        idx    = '0;
        onehot = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = VEC_W'(i);
            end
        end
        if (any) onehot[idx] = 1'b1;
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter logic [NUM_SRC-1:0] LEVEL_MASK = 8'b1100_0000,
    localparam int VEC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic [NUM_SRC-1:0] flag_clr,
    input  logic               gie_set,
    input  logic               gie_clr,
    input  logic               ack,
    input  logic               reti,
    input  logic               retired,
    output logic               irq_req,
    output logic [VEC_W-1:0]   irq_vec,
    output logic [VEC_W-1:0]   taken_vec,
    output logic               gie,
    output logic [NUM_SRC-1:0] flags
);
    typedef struct packed {
        logic             gie;
        logic             hold;
        logic [VEC_W-1:0] taken;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NUM_SRC-1:0] pend_raw;
    logic [NUM_SRC-1:0] pend_en;
    logic [NUM_SRC-1:0] win_onehot;
    logic [NUM_SRC-1:0] hw_clr;
    logic               win_any;
    logic [VEC_W-1:0]   win_idx;
    logic               take;

    irq_flag_bank #(
        .NUM_SRC   (NUM_SRC),
        .LEVEL_MASK(LEVEL_MASK)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_in  (src_in),
        .sw_clr  (flag_clr),
        .hw_clr  (hw_clr),
        .pend_raw(pend_raw)
    );

    assign pend_en = pend_raw & src_en;

    irq_prio_enc #(
        .NUM_SRC(NUM_SRC)
    ) u_enc (
        .req   (pend_en),
        .any   (win_any),
        .idx   (win_idx),
        .onehot(win_onehot)
    );

    assign irq_req = win_any && ctl_q.gie && !ctl_q.hold && !gie_clr;
    assign take    = irq_req && ack;
    assign hw_clr  = take ? win_onehot : '0;

    always_comb begin
        ctl_d = ctl_q;
        if (gie_set || reti) ctl_d.gie = 1'b1;
        if (gie_clr || take) ctl_d.gie = 1'b0;
        if (reti)            ctl_d.hold = 1'b1;
        else if (retired)    ctl_d.hold = 1'b0;
        if (take)            ctl_d.taken = win_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign irq_vec   = win_idx;
    assign taken_vec = ctl_q.taken;
    assign gie       = ctl_q.gie;
    assign flags     = pend_raw;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
    parameter int NUM_SRC = 8,
    parameter logic [NUM_SRC-1:0] LEVEL_MASK = '0,
    localparam int VEC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_in,
    input logic [NUM_SRC-1:0] src_en,
    input logic [NUM_SRC-1:0] flag_clr,
    input logic               gie_set,
    input logic               gie_clr,
    input logic               ack,
    input logic               reti,
    input logic               retired,
    input logic               irq_req,
    input logic [VEC_W-1:0]   irq_vec,
    input logic [VEC_W-1:0]   taken_vec,
    input logic               gie,
    input logic [NUM_SRC-1:0] flags
);
    logic [NUM_SRC-1:0] live;
    logic               below_clear;

    assign live = flags & src_en;

    always_comb begin
        below_clear = 1'b1;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (VEC_W'(i) < irq_vec && live[i]) below_clear = 1'b0;
        end
    end

    AST_VEC_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (below_clear && live[irq_vec])); // R1

    AST_TAKE_DROPS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && ack) |=> !gie); // R5

    AST_TAKEN_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && ack) |=> (taken_vec == $past(irq_vec))); // R5

    AST_RETI_RAISES_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !gie_clr && !(irq_req && ack)) |=> gie); // R6

    AST_HOLD_AFTER_RETI: assert property (@(posedge clk) disable iff (!rst_n)
        reti |=> !irq_req); // R7

    AST_CLR_MASKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        gie_clr |-> !irq_req); // R8

    AST_REQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> gie); // R10

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        if (!LEVEL_MASK[g]) begin : g_latched
            AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
                src_in[g] |=> flags[g]); // R2
            AST_SW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
                (flag_clr[g] && !src_in[g]) |=> !flags[g]); // R3
        end else begin : g_level
            AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
                flags[g] == src_in[g]); // R4
        end
    end
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
    .NUM_SRC   (NUM_SRC),
    .LEVEL_MASK(LEVEL_MASK)
) u_chk (.*);

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;
    localparam int N = 8;
    localparam logic [N-1:0] LVL = 8'b1100_0000;
    localparam int VW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] src_in = '0, src_en = '0, flag_clr = '0;
    logic gie_set = 0, gie_clr = 0, ack = 0, reti = 0, retired = 0;
    logic irq_req, gie;
    logic [VW-1:0] irq_vec, taken_vec;
    logic [N-1:0] flags;

    int n_chk = 0;
    int n_fail = 0;

    bit m_flag [N];
    bit m_gie, m_hold;
    int m_taken;

    always #4 clk = ~clk;

    prio_irq_ctrl #(.NUM_SRC(N), .LEVEL_MASK(LVL)) i_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .src_en(src_en),
        .flag_clr(flag_clr), .gie_set(gie_set), .gie_clr(gie_clr), .ack(ack),
        .reti(reti), .retired(retired), .irq_req(irq_req), .irq_vec(irq_vec),
        .taken_vec(taken_vec), .gie(gie), .flags(flags)
    );

    task automatic chk(input int act, input int exp, input string req);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    function automatic bit m_raw(input int i);
        return LVL[i] ? src_in[i] : m_flag[i];
    endfunction

    function automatic int m_win();
        for (int i = 0; i < N; i++) if (m_raw(i) && src_en[i]) return i;
        return -1;
    endfunction

    function automatic bit m_req();
        return (m_win() >= 0) && m_gie && !m_hold && !gie_clr;
    endfunction

    // compare all outputs with the model, then advance the model one edge
    task automatic step();
        int w;
        bit rq, tk;
        #1;
        w  = m_win();
        rq = m_req();
        tk = rq && ack;
        chk(irq_req, rq, "R10 irq_req");
        if (rq) chk(irq_vec, w, "R1 irq_vec");
        chk(gie, m_gie, "R6 gie");
        chk(taken_vec, m_taken, "R5 taken_vec");
        for (int i = 0; i < N; i++)
            chk(flags[i], m_raw(i), LVL[i] ? "R4 level flag" : "R2 latched flag");
        @(posedge clk);
        for (int i = 0; i < N; i++) begin
            if (!LVL[i]) begin
                if (src_in[i]) m_flag[i] = 1;
                else if (flag_clr[i] || (tk && w == i)) m_flag[i] = 0;
            end
        end
        if (tk || gie_clr) m_gie = 0;
        else if (reti || gie_set) m_gie = 1;
        if (reti) m_hold = 1;
        else if (retired) m_hold = 0;
        if (tk) m_taken = w;
        @(negedge clk);
    endtask

    task automatic idle();
        src_in = '0; flag_clr = '0; gie_set = 0; gie_clr = 0;
        ack = 0; reti = 0; retired = 0;
    endtask

    initial begin
        #1600000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) m_flag[i] = 0;
        m_gie = 0; m_hold = 0; m_taken = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk(irq_req, 0, "R10 reset req");
        chk(gie, 0, "R6 reset gie");
        chk(flags, 0, "R2 reset flags");
        #1;

        // R2: events latch with every enable off
        src_in[3] = 1; src_in[5] = 1; step(); idle();
        step();
        chk(flags[3], 1, "R2 flag3 held"); chk(irq_req, 0, "R10 no gie");
        // R4: level pulse while disabled leaves nothing
        src_in[6] = 1; step(); idle(); step();
        src_en = 8'b0110_1000;
        chk(flags[6], 0, "R4 level gone");
        gie_set = 1; step(); idle();
        #1;
        chk(irq_req, 1, "R1 req"); chk(irq_vec, 3, "R1 lowest wins");
        #1;
        // R5 and R3: acknowledge, with a new event on flag 3 at the same time
        ack = 1; src_in[3] = 1; step(); idle();
        chk(gie, 0, "R5 gie dropped"); chk(taken_vec, 3, "R5 taken");
        chk(flags[3], 1, "R3 event beats hw clear");
        // R3: W1C on flag 3
        flag_clr[3] = 1; step(); idle();
        chk(flags[3], 0, "R3 sw clear");
        // R7: return, hold until retire
        reti = 1; step(); idle();
        chk(irq_req, 0, "R7 hold after reti"); chk(gie, 1, "R6 reti sets gie");
        step(); step();
        retired = 1; step(); idle();
        chk(irq_req, 1, "R7 open after retire"); chk(irq_vec, 5, "R1 next");
        // R8: same-cycle disable
        gie_clr = 1; #1; chk(irq_req, 0, "R8 immediate mask"); #1;
        step(); idle();
        gie_set = 1; step(); idle();
        // R9: take 5, re-enable inside handler, level 6 then taken
        ack = 1; step(); idle();
        src_in[6] = 1; gie_set = 1; step();
        #1; chk(irq_req, 1, "R9 nested req"); chk(irq_vec, 6, "R9 nested vec"); #1;
        ack = 1; step(); idle();
        chk(taken_vec, 6, "R9 nested taken");
        reti = 1; retired = 1; step(); idle();

        // random phase
        for (int c = 0; c < 20000; c++) begin
            for (int i = 0; i < N; i++) begin
                if (LVL[i]) begin
                    if ($urandom_range(0, 9) == 0) src_in[i] = ~src_in[i];
                end else begin
                    src_in[i] = ($urandom_range(0, 9) == 0);
                end
                flag_clr[i] = ($urandom_range(0, 19) == 0);
                if ($urandom_range(0, 49) == 0) src_en[i] = ~src_en[i];
            end
            ack     = $urandom_range(0, 1);
            reti    = ($urandom_range(0, 7) == 0);
            retired = ($urandom_range(0, 2) == 0);
            gie_set = ($urandom_range(0, 9) == 0);
            gie_clr = ($urandom_range(0, 19) == 0);
            step();
        end
        idle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule